// File: doc/BRIEF.md
# Time-Division Multiplexed Frame Serializer

This block sends a repeating frame of byte-wide channels over a single serial data line. A free-running frame counter advances once per bit clock. Its low bits give the bit position inside the current byte and its high bits give the timeslot. With the default parameters there are 32 timeslots of 8 bits, so one frame lasts 256 bit clocks. At a 2.048 Mb/s line rate this gives 8000 frames per second, and each channel carries 64 kb/s.

The block presents all channel bytes in parallel on one flat input bus. During the final bit time of each timeslot, it picks the byte that belongs to the following timeslot and loads it into a parallel-in, serial-out register. That register then shifts the byte out most significant bit first, so each slot's byte goes out during that slot's own bit times. A frame marker is high during the last bit time of every frame, and the current timeslot number is presented as an output.

An optional substitution mode protects clock recovery downstream. When it is enabled, a byte of all zeros is sent as the fixed code 00000010, so the line never carries a long run of zeros.

Top module: `tdm_frame_tx`

## Requirements
- R1: While rst_n is low, slot_num is 0, ser_data is 0 and frame_mark is 0.
- R2: The frame counter advances by one on every clock after reset. slot_num holds each value for 8 consecutive clocks, counts 0 to 31, and wraps from 31 to 0.
- R3: frame_mark is high for exactly one clock in every 256. That clock is bit position 7 of slot 31, the last bit of the frame, and the next clock is bit position 0 of slot 0.
- R4: During the 8 clocks of slot s, ser_data carries bits 7 down to 0 of source byte s, most significant bit first. Source byte s is src_bytes[8*s+7 : 8*s].
- R5: The byte for slot s is sampled only during the last bit time of slot s-1, taken modulo 32. A change to src_bytes while slot s is being sent has no effect on slot s, but it does affect the next slot that is loaded afterwards.
- R6: The first slot 0 after reset is sent as eight zero bits, whatever src_bytes holds.
- R7: When zero_sub_en is 1 at the load of a slot whose source byte is 00000000, the slot is sent as 00000010.
- R8: When zero_sub_en is 1, every non-zero source byte is sent unchanged, including 00000010 and 10000000.
- R9: When zero_sub_en is 0, an all-zero source byte is sent as eight zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| zero_sub_en | input | 1 | Enables substitution of all-zero bytes, sampled at each load |
| src_bytes | input | 256 | Parallel channel bytes; slot s at bits [8*s+7:8*s] |
| ser_data | output | 1 | Serial data, most significant bit of each byte first |
| frame_mark | output | 1 | High during the last bit time of each frame |
| slot_num | output | 5 | Timeslot currently being sent |

## Verification
slot_num and frame_mark are decoded directly from the counter register, so they change one clock after reset is released and then step once per clock. Serial bits lag the source sampling by exactly one register: a byte is captured at the edge that ends bit 7 of the previous slot, and its bits appear on the eight clocks of its own slot. The bench changes src_bytes and zero_sub_en on the falling edge during the frame marker, so the settings apply to every slot of the following frame. It samples every output on falling edges, counting from the frame marker. The mid-frame case changes the inputs three clocks into a slot's transmission, which checks that this slot keeps its old byte and that the next slot takes the new one.

// File: rtl/tdm_pkg.sv
// Package: tdm_pkg
// Shared defaults for the frame serializer and a helper that applies the
// all-zero byte substitution. Assumes byte widths of at least 2 bits.
package tdm_pkg;

    localparam int DEF_SLOTS  = 32;
    localparam int DEF_BYTE_W = 8;

    // Return the byte to transmit for a raw source byte under the enable.
    function automatic logic [DEF_BYTE_W-1:0] sub_zero_byte(
        input logic [DEF_BYTE_W-1:0] raw,
        input logic                  en
    );
        logic [DEF_BYTE_W-1:0] code;
        code = DEF_BYTE_W'(2);
        if (en && (raw == '0))
            return code;
        return raw;
    endfunction

endpackage

// File: rtl/tdm_bit_counter.sv
// Module: tdm_bit_counter
// Free-running frame position counter. The low bits are the bit position
// inside a byte and the high bits are the timeslot. It also decodes the
// load strobe (last bit of a slot) and the frame end (last bit of a frame).
// Assumes SLOTS and BYTE_W are powers of two.
module tdm_bit_counter #(
    parameter int SLOTS  = 32,
    parameter int BYTE_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    output logic [$clog2(SLOTS*BYTE_W)-1:0]   cnt,
    output logic [$clog2(SLOTS)-1:0]          slot,
    output logic [$clog2(BYTE_W)-1:0]         bitpos,
    output logic                              load_now,
    output logic                              frame_end
);
    localparam int CNT_W  = $clog2(SLOTS*BYTE_W);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(SLOTS*BYTE_W - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

    logic [CNT_W-1:0] cnt_q;

    // Advance the frame position once per clock, wrapping at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == CNT_MAX)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

    // Split the count into slot and bit position and decode the strobes.
    always_comb begin
        cnt       = cnt_q;
        bitpos    = cnt_q[BIT_W-1:0];
        slot      = cnt_q[CNT_W-1 -: SLOT_W];
        load_now  = (cnt_q[BIT_W-1:0] == BIT_LAST);
        frame_end = (cnt_q == CNT_MAX);
    end

endmodule

// File: rtl/tdm_slot_mux.sv
// Module: tdm_slot_mux
// Picks the source byte of the slot after the current one (wrapping to
// slot 0) and applies the optional all-zero substitution. Purely
// combinational; the caller decides when to use the result.
module tdm_slot_mux #(
    parameter int                SLOTS    = 32,
    parameter int                BYTE_W   = 8,
    parameter logic [BYTE_W-1:0] SUB_CODE = BYTE_W'(2)
) (
    input  logic [$clog2(SLOTS)-1:0]   slot_cur,
    input  logic [SLOTS*BYTE_W-1:0]    src_flat,
    input  logic                       zero_sub_en,
    output logic [$clog2(SLOTS)-1:0]   slot_nxt,
    output logic [BYTE_W-1:0]          raw_byte,
    output logic [BYTE_W-1:0]          tx_byte
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

    logic [BYTE_W-1:0] src_arr [SLOTS];

    // Unpack the flat bus so that slot s sits in its own array element.
    for (genvar s = 0; s < SLOTS; s++) begin : g_unpack
        assign src_arr[s] = src_flat[s*BYTE_W +: BYTE_W];
    end

    // Work out the upcoming slot, modulo the slot count.
    always_comb begin
        if (slot_cur == SLOT_LAST)
            slot_nxt = '0;
        else
            slot_nxt = slot_cur + SLOT_W'(1);
    end

    // Select the upcoming slot's byte and substitute an all-zero byte.
    always_comb begin
        raw_byte = src_arr[slot_nxt];
        if (zero_sub_en && (raw_byte == '0))
            tx_byte = SUB_CODE;
        else
            tx_byte = raw_byte;
    end

endmodule

// File: rtl/tdm_piso.sv
// Module: tdm_piso
// Parallel-in, serial-out register. A load takes in a whole byte; every
// other clock shifts left by one, filling with zero. The serial output is
// the most significant bit. Reset clears the register.
module tdm_piso #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] shreg,
    output logic              sout
);
    logic [BYTE_W-1:0] sh_q;

    // Load a new byte at the slot boundary, otherwise shift one bit out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else if (load)
            sh_q <= din;
        else
            sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
    end

    // Expose the register and its leading bit.
    always_comb begin
        shreg = sh_q;
        sout  = sh_q[BYTE_W-1];
    end

endmodule

// File: rtl/tdm_frame_tx.sv
// Module: tdm_frame_tx
// Top level of the TDM frame serializer. It ties together the frame
// counter, the next-slot byte selector and the shift register. The frame
// marker and slot number come straight from the counter register. Assumes
// src_bytes is stable around the load edge at the end of each slot.
module tdm_frame_tx #(
    parameter int                SLOTS    = tdm_pkg::DEF_SLOTS,
    parameter int                BYTE_W   = tdm_pkg::DEF_BYTE_W,
    parameter logic [BYTE_W-1:0] SUB_CODE = BYTE_W'(2)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        zero_sub_en,
    input  logic [SLOTS*BYTE_W-1:0]     src_bytes,
    output logic                        ser_data,
    output logic                        frame_mark,
    output logic [$clog2(SLOTS)-1:0]    slot_num
);
    localparam int CNT_W  = $clog2(SLOTS*BYTE_W);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int BIT_W  = $clog2(BYTE_W);

    logic [CNT_W-1:0]  cnt;
    logic [SLOT_W-1:0] slot_cur;
    logic [SLOT_W-1:0] slot_nxt;
    logic [BIT_W-1:0]  bitpos;
    logic              load_now;
    logic              frame_end;
    logic [BYTE_W-1:0] raw_byte;
    logic [BYTE_W-1:0] tx_byte;
    logic [BYTE_W-1:0] shreg;
    logic              sout;

    tdm_bit_counter #(
        .SLOTS  (SLOTS),
        .BYTE_W (BYTE_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt       (cnt),
        .slot      (slot_cur),
        .bitpos    (bitpos),
        .load_now  (load_now),
        .frame_end (frame_end)
    );

    tdm_slot_mux #(
        .SLOTS    (SLOTS),
        .BYTE_W   (BYTE_W),
        .SUB_CODE (SUB_CODE)
    ) u_mux (
        .slot_cur    (slot_cur),
        .src_flat    (src_bytes),
        .zero_sub_en (zero_sub_en),
        .slot_nxt    (slot_nxt),
        .raw_byte    (raw_byte),
        .tx_byte     (tx_byte)
    );

    tdm_piso #(
        .BYTE_W (BYTE_W)
    ) u_piso (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_now),
        .din   (tx_byte),
        .shreg (shreg),
        .sout  (sout)
    );

    // Drive the outputs from the counter decode and the shift register.
    always_comb begin
        ser_data   = sout;
        frame_mark = frame_end;
        slot_num   = slot_cur;
    end

endmodule

// File: rtl/tdm_frame_tx_chk.sv
// Module: tdm_frame_tx_chk
// Assertion checker for tdm_frame_tx, attached with the bind at the end of
// this file. It observes the counter, the load strobe, the selector and the
// shift register.
module tdm_frame_tx_chk #(
    parameter int SLOTS  = 32,
    parameter int BYTE_W = 8
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              zero_sub_en,
    input logic [$clog2(SLOTS*BYTE_W)-1:0]   cnt,
    input logic                              load_now,
    input logic [BYTE_W-1:0]                 raw_byte,
    input logic [BYTE_W-1:0]                 tx_byte,
    input logic [BYTE_W-1:0]                 shreg,
    input logic                              ser_data,
    input logic                              frame_mark,
    input logic [$clog2(SLOTS)-1:0]          slot_num
);
    localparam int CNT_W = $clog2(SLOTS*BYTE_W);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1)))); // R2

    AST_MARK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_mark |=> (!frame_mark && slot_num == '0)); // R3

    AST_LOAD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        load_now |=> (ser_data == $past(tx_byte[BYTE_W-1]))); // R4

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_now |=> (shreg == {$past(shreg[BYTE_W-2:0]), 1'b0})); // R5

    AST_ZERO_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_sub_en && raw_byte == '0) |-> (tx_byte == BYTE_W'(2))); // R7

    AST_NONZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_byte != '0) |-> (tx_byte == raw_byte)); // R8

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 || rst_n)); // R1

endmodule

bind tdm_frame_tx tdm_frame_tx_chk #(
    .SLOTS  (SLOTS),
    .BYTE_W (BYTE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .zero_sub_en (zero_sub_en),
    .cnt         (cnt),
    .load_now    (load_now),
    .raw_byte    (raw_byte),
    .tx_byte     (tx_byte),
    .shreg       (shreg),
    .ser_data    (ser_data),
    .frame_mark  (frame_mark),
    .slot_num    (slot_num)
);

// File: tb/tdm_frame_tx_test.sv
// Directed bench for tdm_frame_tx. Inputs change on falling edges, outputs
// are sampled on falling edges, and frames are captured starting from the
// falling edge at which frame_mark is seen high.
module tdm_frame_tx_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         zero_sub_en = 1'b0;
    logic [255:0] src_bytes;
    logic         ser_data;
    logic         frame_mark;
    logic [4:0]   slot_num;

    logic [7:0] src [32];
    logic [7:0] mut_src [32];
    logic [7:0] rx [32];
    int total = 0;
    int bad = 0;
    int mis_slot;
    int mis_mark;

    always #4 clk = ~clk;

    always_comb begin
        for (int s = 0; s < 32; s++) src_bytes[s*8 +: 8] = src[s];
    end

    tdm_frame_tx uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .zero_sub_en (zero_sub_en),
        .src_bytes   (src_bytes),
        .ser_data    (ser_data),
        .frame_mark  (frame_mark),
        .slot_num    (slot_num)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [7:0] b, input logic en);
        return (en && b == 8'h00) ? 8'h02 : b;
    endfunction

    // Advance to the falling edge at which frame_mark is high.
    task automatic wait_mark();
        @(negedge clk);
        while (!frame_mark) @(negedge clk);
    endtask

    // Capture one frame of 256 bits; apply mut_src at index mut_at (if >= 0).
    task automatic capture_frame(input int mut_at);
        mis_slot = 0;
        mis_mark = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (slot_num != 5'(i / 8)) mis_slot++;
            if (frame_mark != (i == 255)) mis_mark++;
            rx[i/8] = {rx[i/8][6:0], ser_data};
            if (i == mut_at)
                for (int s = 0; s < 32; s++) src[s] = mut_src[s];
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        for (int s = 0; s < 32; s++) src[s] = 8'hA5;
        repeat (3) @(negedge clk);
        chk(slot_num == 5'd0 && ser_data == 1'b0 && frame_mark == 1'b0,
            "R1 reset outputs", {slot_num, ser_data, frame_mark}, 0);
    endtask

    // R6: first slot 0 after reset is all zero; R2 slot number holds for 8.
    task automatic t_first_slot();
        logic [7:0] got;
        int slot_err;
        got = '0;
        slot_err = 0;
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (i > 0) @(negedge clk);
            got = {got[6:0], ser_data};
            if (slot_num != 5'd0) slot_err++;
        end
        chk(got == 8'h00, "R6 first slot 0 zero", got, 0);
        @(negedge clk);
        chk(slot_err == 0 && slot_num == 5'd1, "R2 slot advance after 8", slot_num, 1);
    endtask

    task automatic t_frame(input logic en, input string tag);
        logic [7:0] prev [32];
        wait_mark();
        zero_sub_en = en;
        for (int s = 0; s < 32; s++) prev[s] = src[s];
        capture_frame(-1);
        chk(mis_slot == 0, "R2 slot sequence", mis_slot, 0);
        chk(mis_mark == 0, "R3 frame mark position", mis_mark, 0);
        for (int s = 0; s < 32; s++)
            chk(rx[s] == exp_byte(prev[s], en), tag, rx[s], exp_byte(prev[s], en));
    endtask

    // R5: change slot 5 and 6 bytes three bits into slot 5.
    task automatic t_midframe();
        logic [7:0] prev [32];
        wait_mark();
        zero_sub_en = 1'b0;
        for (int s = 0; s < 32; s++) begin
            src[s] = 8'(s * 9 + 3);
            prev[s] = src[s];
            mut_src[s] = src[s];
        end
        mut_src[5] = 8'h3C;
        mut_src[6] = 8'hC3;
        capture_frame(43);
        chk(rx[5] == prev[5], "R5 slot kept during send", rx[5], prev[5]);
        chk(rx[6] == 8'hC3, "R5 next slot takes new byte", rx[6], 8'hC3);
        chk(rx[4] == prev[4] && rx[7] == prev[7], "R4 neighbours intact", rx[4], prev[4]);
    endtask

    initial begin
        t_reset();
        t_first_slot();
        // Pattern with zeros, raw mode: R4 and R9
        for (int s = 0; s < 32; s++) src[s] = (s % 4 == 0) ? 8'h00 : 8'(s * 37 + 1);
        t_frame(1'b0, "R9 R4 raw byte");
        // Same pattern, substitution on: R7 and R8
        t_frame(1'b1, "R7 R8 substituted byte");
        // Edge values with substitution: R8
        for (int s = 0; s < 32; s++) begin
            case (s % 4)
                0: src[s] = 8'h80;
                1: src[s] = 8'h02;
                2: src[s] = 8'hFF;
                default: src[s] = 8'h00;
            endcase
        end
        t_frame(1'b1, "R8 edge bytes kept");
        // Alternating bits, raw mode: R4 bit order
        for (int s = 0; s < 32; s++) src[s] = s[0] ? 8'h55 : 8'h01;
        t_frame(1'b0, "R4 bit order");
        t_midframe();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule